// File: doc/BRIEF.md
# Event Performance Counter Unit

This block gives a core a small set of 32-bit event counters and one dedicated 32-bit cycle counter. Each event counter watches one of 256 single-bit event pulse inputs, picked by an 8-bit event code held per counter. Software runs the block through a synchronous register port: an address, a write strobe, write data and a combinational read-data return.

A global control register gates all counting, issues one-shot resets for the event counters and for the cycle counter, and can slow the cycle counter to one step per 64 clocks. Counter enables and overflow-interrupt enables each have a write-one-to-set address and a write-one-to-clear address. Overflows are latched in a flag register that is cleared by writing ones. All enabled flags are ORed onto one interrupt line. The event counters are not mapped one by one. A counter-select register steers a single count window and a single event-code window onto one of them.

Top module: `perf_counter_unit`

## Requirements
- R1: While control bit 0 (global enable, control register at address 0x0) is 0, neither the event counters nor the cycle counter advance.
- R2: A write to the control register with bit 1 set clears every event counter to 0. A write with bit 2 set clears the cycle counter and its prescaler to 0. Both bits read back as 0. A reset of one kind leaves the other counter kind untouched.
- R3: With control bit 3 set, the cycle counter steps once per 64 enabled clocks: the first step comes on the 64th clock edge after a cycle reset, the second on the 128th.
- R4: The control register stores bits [5:0] only. A read returns the stored bits 0, 3, 4 and 5, zero in bits 1 and 2, the number of event counters N in bits [15:11], and zero everywhere else. After reset it reads N<<11.
- R5: In the counter-enable mask, the interrupt-enable mask and the flag register, bit 31 belongs to the cycle counter and bits 0..N-1 belong to event counters 0..N-1. All other bits read 0.
- R6: A write to 0x1 (enable set) ORs the data into the counter-enable mask. A write to 0x2 (enable clear) removes the 1-bits of the data from it. Addresses 0x3 and 0x4 do the same for the interrupt-enable mask. Zero data bits change nothing. Both addresses of a pair read the current mask.
- R7: A counter stepping from 0xFFFFFFFF to 0 sets its flag bit in the flag register at 0x5. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R8: The 5-bit select register at 0x6 picks the event counter reached through the count window at 0x8 and the 8-bit event-code window at 0x9. The cycle counter is read and written directly at 0x7. A write to a counter takes effect at the next clock edge.
- R9: The interrupt output is high exactly while some flag bit is set whose interrupt-enable bit is also set.
- R10: With a select value of N or more, reads of 0x8 and 0x9 return 0, and writes to them change no counter and no event code.
- R11: If a flag clear and a new overflow of the same counter fall on the same clock edge, the flag stays set.
- R12: An event counter steps by one on an edge where the global enable, its own enable bit and its chosen event input are all high. A write to that counter on the same edge wins over the step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_in | input | 256 | Event pulse inputs, one bit per event code |
| irq_o | output | 1 | Combined overflow interrupt |

## Verification
Reads are combinational, so a register's value is visible in the same cycle its address is presented. A write, a counter step, a reset pulse and an overflow flag each appear after the first rising edge that samples them. The interrupt follows the flag with no extra cycle. The prescaled cycle counter moves only on every 64th enabled edge. The bench changes inputs at falling edges and samples one nanosecond later. This places every check a known whole number of rising edges after its stimulus, and the expected values count exactly those edges, including the edge of the write that changes the enable.

// File: rtl/pmu_pkg.sv
// Package pmu_pkg
// Shared constants of the performance counter unit: register addresses,
// control bit positions and fixed field widths. Assumes a 32-bit data bus.
package pmu_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int SEL_W     = 5;
    localparam int EVSEL_W   = 8;
    localparam int EV_N      = 1 << EVSEL_W;
    localparam int CYC_BIT   = 31;
    localparam int NUM_LSB   = 11;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_ENS  = 4'h1;
    localparam logic [ADDR_W-1:0] A_ENC  = 4'h2;
    localparam logic [ADDR_W-1:0] A_IES  = 4'h3;
    localparam logic [ADDR_W-1:0] A_IEC  = 4'h4;
    localparam logic [ADDR_W-1:0] A_FLG  = 4'h5;
    localparam logic [ADDR_W-1:0] A_SEL  = 4'h6;
    localparam logic [ADDR_W-1:0] A_CYC  = 4'h7;
    localparam logic [ADDR_W-1:0] A_CNT  = 4'h8;
    localparam logic [ADDR_W-1:0] A_EVS  = 4'h9;

    localparam int C_EN    = 0;
    localparam int C_EVRST = 1;
    localparam int C_CYRST = 2;
    localparam int C_DIV   = 3;
    localparam int CTRL_W  = 6;
endpackage

// File: rtl/pmu_mask_reg.sv
// Module pmu_mask_reg
// A mask register with separate write-one-to-set and write-one-to-clear
// strobes. Bits outside VALID never become 1. Assumes set and clear strobes
// come from different addresses, so they are never both high.
module pmu_mask_reg
    import pmu_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_o
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;

    // Qualify write data by its strobe.
    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    // Mask state: OR in set bits, remove clear bits, keep to VALID.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= ((mask_q | set_bits) & ~clr_bits) & VALID;
    end

    assign mask_o = mask_q;

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/pmu_event_counter.sv
// Module pmu_event_counter
// One event counter with its own event-code register. It steps by one when
// the global and own enables are high and the chosen event input is high. The
// group clear has first priority, then a direct write, then the step. It
// reports an overflow pulse when a step wraps the all-ones value to 0.
module pmu_event_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en,
    input  logic               own_en,
    input  logic [EV_N-1:0]    ev_in,
    input  logic               clr_all,
    input  logic               wr_cnt,
    input  logic               wr_code,
    input  logic [CNT_W-1:0]   wdata_cnt,
    input  logic [EVSEL_W-1:0] wdata_code,
    output logic [CNT_W-1:0]   count_o,
    output logic [EVSEL_W-1:0] code_o,
    output logic               ovf_o
);
    logic [CNT_W-1:0]   count_q;
    logic [EVSEL_W-1:0] code_q;
    logic               step;

    // Step request and wrap detection for this edge.
    always_comb begin
        step  = glob_en & own_en & ev_in[code_q];
        ovf_o = step & ~clr_all & ~wr_cnt & (count_q == '1);
    end

    // Count register: clear, then write, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (clr_all) count_q <= '0;
        else if (wr_cnt)  count_q <= wdata_cnt;
        else if (step)    count_q <= count_q + 1'b1;
    end

    // Event-code register, written only through the window.
    always_ff @(posedge clk) begin
        if (!rst_n)       code_q <= '0;
        else if (wr_code) code_q <= wdata_code;
    end

    assign count_o = count_q;
    assign code_o  = code_q;

    assert_gated_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !clr_all && !wr_cnt) |=> $stable(count_q));

    assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !wr_cnt) |=>
            (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/pmu_cycle_counter.sv
// Module pmu_cycle_counter
// The dedicated cycle counter with a prescaler. While counting is active the
// prescaler runs every clock. In divide mode the counter steps only when the
// prescaler is all ones, otherwise every clock. The clear has priority over a
// write, and a write has priority over a step.
module pmu_cycle_counter #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             own_en,
    input  logic             div_en,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] count_q;
    logic [PRE_W-1:0] pre_q;
    logic             active;
    logic             tick;

    // Counting condition and prescaled tick.
    always_comb begin
        active = glob_en & own_en;
        tick   = active & (~div_en | (pre_q == '1));
        ovf_o  = tick & ~clr & ~wr & (count_q == '1);
    end

    // Prescaler: cleared with the counter, free-running while active.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else if (active)   pre_q <= pre_q + 1'b1;
    end

    // Cycle count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (clr)  count_q <= '0;
        else if (wr)   count_q <= wdata;
        else if (tick) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    assert_prescale_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && !clr && !wr && pre_q != '1) |=> $stable(count_q));

    assert_cycle_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !clr && !wr) |=> $stable(count_q));
endmodule

// File: rtl/perf_counter_unit.sv
// Module perf_counter_unit
// Top of the performance counter unit. It decodes the register port, holds
// the control, select and flag registers, instantiates N event counters and
// the cycle counter, and drives the combined interrupt. Assumes 1 <= N_CNT <= 31
// and CNT_W <= 32. Reads are combinational on reg_addr.
module perf_counter_unit
    import pmu_pkg::*;
#(
    parameter int N_CNT = 4,
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EV_N-1:0]   ev_in,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] EV_BITS = 32'((64'd1 << N_CNT) - 64'd1);
    localparam logic [DATA_W-1:0] VALID   = EV_BITS | (32'd1 << CYC_BIT);
    localparam logic [CTRL_W-1:0] STORE_M = ~(CTRL_W'(1 << C_EVRST) | CTRL_W'(1 << C_CYRST));

    logic [CTRL_W-1:0]  ctrl_q;
    logic [SEL_W-1:0]   sel_q;
    logic [DATA_W-1:0]  flags_q;
    logic [DATA_W-1:0]  en_mask;
    logic [DATA_W-1:0]  ie_mask;
    logic [DATA_W-1:0]  ovf_vec;
    logic [N_CNT-1:0]   ev_ovf;
    logic [CNT_W-1:0]   ev_count [N_CNT];
    logic [EVSEL_W-1:0] ev_code  [N_CNT];
    logic [CNT_W-1:0]   cyc_count;
    logic               cyc_ovf;
    logic               we_ctrl, we_flg, we_sel, we_cyc, we_cnt, we_evs;
    logic               ev_rst, cy_rst;
    logic [DATA_W-1:0]  flg_clr;
    logic [DATA_W-1:0]  win_cnt;
    logic [DATA_W-1:0]  win_evs;

    // Write strobes per address and the self-clearing reset pulses.
    always_comb begin
        we_ctrl = reg_we && (reg_addr == A_CTRL);
        we_flg  = reg_we && (reg_addr == A_FLG);
        we_sel  = reg_we && (reg_addr == A_SEL);
        we_cyc  = reg_we && (reg_addr == A_CYC);
        we_cnt  = reg_we && (reg_addr == A_CNT);
        we_evs  = reg_we && (reg_addr == A_EVS);
        ev_rst  = we_ctrl && reg_wdata[C_EVRST];
        cy_rst  = we_ctrl && reg_wdata[C_CYRST];
        flg_clr = we_flg ? reg_wdata : '0;
    end

    // Control register: stores the level bits, never the pulse bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (we_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0] & STORE_M;
    end

    // Counter-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (we_sel) sel_q <= reg_wdata[SEL_W-1:0];
    end

    pmu_mask_reg #(.VALID(VALID)) u_en_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (reg_we && (reg_addr == A_ENS)),
        .clr_we (reg_we && (reg_addr == A_ENC)),
        .wdata  (reg_wdata),
        .mask_o (en_mask)
    );

    pmu_mask_reg #(.VALID(VALID)) u_ie_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (reg_we && (reg_addr == A_IES)),
        .clr_we (reg_we && (reg_addr == A_IEC)),
        .wdata  (reg_wdata),
        .mask_o (ie_mask)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_evc
        pmu_event_counter #(.CNT_W(CNT_W)) u_evc (
            .clk        (clk),
            .rst_n      (rst_n),
            .glob_en    (ctrl_q[C_EN]),
            .own_en     (en_mask[i]),
            .ev_in      (ev_in),
            .clr_all    (ev_rst),
            .wr_cnt     (we_cnt && (sel_q == SEL_W'(i))),
            .wr_code    (we_evs && (sel_q == SEL_W'(i))),
            .wdata_cnt  (reg_wdata[CNT_W-1:0]),
            .wdata_code (reg_wdata[EVSEL_W-1:0]),
            .count_o    (ev_count[i]),
            .code_o     (ev_code[i]),
            .ovf_o      (ev_ovf[i])
        );
    end

    pmu_cycle_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .glob_en (ctrl_q[C_EN]),
        .own_en  (en_mask[CYC_BIT]),
        .div_en  (ctrl_q[C_DIV]),
        .clr     (cy_rst),
        .wr      (we_cyc),
        .wdata   (reg_wdata[CNT_W-1:0]),
        .count_o (cyc_count),
        .ovf_o   (cyc_ovf)
    );

    // Collect overflow pulses into flag bit positions.
    always_comb begin
        ovf_vec                = '0;
        ovf_vec[N_CNT-1:0]     = ev_ovf;
        ovf_vec[CYC_BIT]       = cyc_ovf;
    end

    // Flag register: write-one-to-clear, a new overflow wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= ((flags_q & ~flg_clr) | ovf_vec) & VALID;
    end

    // Combined interrupt from enabled flags.
    assign irq_o = |(flags_q & ie_mask);

    // Indirect windows onto the selected event counter.
    always_comb begin
        win_cnt = '0;
        win_evs = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (sel_q == SEL_W'(i)) begin
                win_cnt = DATA_W'(ev_count[i]);
                win_evs = DATA_W'(ev_code[i]);
            end
        end
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_W-1:0]        = ctrl_q;
                reg_rdata[NUM_LSB+SEL_W-1:NUM_LSB] = SEL_W'(N_CNT);
            end
            A_ENS, A_ENC: reg_rdata = en_mask;
            A_IES, A_IEC: reg_rdata = ie_mask;
            A_FLG:        reg_rdata = flags_q;
            A_SEL:        reg_rdata = DATA_W'(sel_q);
            A_CYC:        reg_rdata = DATA_W'(cyc_count);
            A_CNT:        reg_rdata = win_cnt;
            A_EVS:        reg_rdata = win_evs;
            default:      reg_rdata = '0;
        endcase
    end

    assert_overflow_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec != '0) |=> ((flags_q & $past(ovf_vec)) == $past(ovf_vec)));

    assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_flg) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags_q != '0 && ie_mask != '0));
endmodule

// File: tb/sim_perf_counter_unit.sv
// Directed bench for perf_counter_unit, N_CNT = 4. Inputs change at falling
// edges; reads sample 1 ns later.
module sim_perf_counter_unit;
    localparam logic [3:0] CTRL = 4'h0, ENS = 4'h1, ENC = 4'h2, IES = 4'h3,
                           IEC = 4'h4, FLG = 4'h5, SEL = 4'h6, CYC = 4'h7,
                           CNT = 4'h8, EVS = 4'h9;
    localparam logic [31:0] NUM_FIELD = 32'h0000_2000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] ev_in = '0;
    logic         irq_o;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 0;

    always #10 clk = ~clk;

    perf_counter_unit #(.N_CNT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R4 reset ctrl", CTRL, NUM_FIELD);
        rd_chk("R6 reset enable", ENS, 32'h0);
        rd_chk("R7 reset flags", FLG, 32'h0);
        chk("R9 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_ctrl_bits;
        wr(CTRL, 32'hFFFF_FFFF);
        rd_chk("R4 writable ctrl bits", CTRL, NUM_FIELD | 32'h39);
        rd_chk("R2 pulse bits read 0", CTRL, NUM_FIELD | 32'h39);
        wr(CTRL, 32'h0);
        rd_chk("R4 ctrl cleared", CTRL, NUM_FIELD);
    endtask

    task automatic t_masks;
        wr(ENS, 32'h8000_0005);
        rd_chk("R6 set via set addr", ENS, 32'h8000_0005);
        rd_chk("R6 read via clear addr", ENC, 32'h8000_0005);
        wr(ENC, 32'h0000_0001);
        rd_chk("R6 clear one bit", ENS, 32'h8000_0004);
        wr(ENS, 32'h0);
        rd_chk("R6 zero set no change", ENS, 32'h8000_0004);
        wr(ENS, 32'hFFFF_FFFF);
        rd_chk("R5 only valid bits", ENS, 32'h8000_000F);
        wr(ENC, 32'hFFFF_FFFF);
        rd_chk("R6 clear all", ENS, 32'h0);
        wr(IES, 32'h0000_0404);
        rd_chk("R5 ie mask valid bits", IEC, 32'h0000_0004);
        wr(IEC, 32'h0000_0004);
        rd_chk("R6 ie clear", IES, 32'h0);
    endtask

    task automatic t_select;
        wr(SEL, 32'd2); wr(EVS, 32'h37);
        wr(SEL, 32'd1); wr(EVS, 32'h10);
        wr(SEL, 32'd2);
        rd_chk("R8 select readback", SEL, 32'd2);
        rd_chk("R8 event code of counter 2", EVS, 32'h37);
        wr(SEL, 32'd1);
        rd_chk("R8 event code of counter 1", EVS, 32'h10);
        wr(CNT, 32'h0000_0A5A);
        rd_chk("R8 indirect count write", CNT, 32'h0000_0A5A);
        wr(CYC, 32'h0000_1234);
        rd_chk("R8 direct cycle write", CYC, 32'h0000_1234);
    endtask

    task automatic t_out_of_range;
        wr(SEL, 32'd6);
        wr(CNT, 32'h55);
        wr(EVS, 32'h22);
        rd_chk("R10 read count out of range", CNT, 32'h0);
        rd_chk("R10 read code out of range", EVS, 32'h0);
        wr(SEL, 32'd1);
        rd_chk("R10 counter 1 untouched", CNT, 32'h0000_0A5A);
        rd_chk("R10 code 1 untouched", EVS, 32'h10);
    endtask

    task automatic t_counting;
        wr(SEL, 32'd0); wr(EVS, 32'd5); wr(CNT, 32'd0);
        wr(ENS, 32'h1); wr(CTRL, 32'h1);
        ev_in[5] = 1'b1; idle(10); ev_in[5] = 1'b0;
        rd_chk("R12 counts chosen event", CNT, 32'd10);
        ev_in[6] = 1'b1; idle(5); ev_in[6] = 1'b0;
        rd_chk("R12 other event ignored", CNT, 32'd10);
        wr(ENC, 32'h1);
        ev_in[5] = 1'b1; idle(5); ev_in[5] = 1'b0;
        rd_chk("R12 own enable off", CNT, 32'd10);
        wr(ENS, 32'h1); wr(CTRL, 32'h0);
        ev_in[5] = 1'b1; idle(5); ev_in[5] = 1'b0;
        rd_chk("R1 global enable off", CNT, 32'd10);
        wr(CTRL, 32'h1);
        ev_in[5] = 1'b1;
        wr(CNT, 32'd100);
        ev_in[5] = 1'b0;
        rd_chk("R12 write wins over step", CNT, 32'd100);
    endtask

    task automatic t_reset_pulses;
        wr(CTRL, 32'h0);
        wr(CYC, 32'h0000_0777);
        wr(CTRL, 32'h2);
        rd_chk("R2 event counters cleared", CNT, 32'd0);
        rd_chk("R2 cycle untouched", CYC, 32'h0000_0777);
        wr(CTRL, 32'h4);
        rd_chk("R2 cycle cleared", CYC, 32'd0);
    endtask

    task automatic t_cycle;
        wr(ENS, 32'h8000_0000);
        wr(CTRL, 32'h5);
        idle(10);
        rd_chk("R1 cycle counts every clock", CYC, 32'd10);
        wr(CTRL, 32'hD);
        idle(63);
        rd_chk("R3 no step before 64", CYC, 32'd0);
        idle(1);
        rd_chk("R3 first step at 64", CYC, 32'd1);
        idle(64);
        rd_chk("R3 second step at 128", CYC, 32'd2);
        wr(CTRL, 32'h0);
    endtask

    task automatic t_overflow;
        wr(IES, 32'h8000_0000);
        wr(CYC, 32'hFFFF_FFFE);
        wr(CTRL, 32'h1);
        rd_chk("R7 no flag before wrap", FLG, 32'h0);
        idle(1);
        rd_chk("R7 at all ones", CYC, 32'hFFFF_FFFF);
        chk("R9 irq low before wrap", {31'b0, irq_o}, 32'h0);
        idle(1);
        wr(CTRL, 32'h0);
        rd_chk("R7 cycle flag set", FLG, 32'h8000_0000);
        chk("R9 irq high", {31'b0, irq_o}, 32'h1);
        wr(FLG, 32'h0);
        rd_chk("R7 zero write keeps flag", FLG, 32'h8000_0000);
        wr(FLG, 32'h8000_0000);
        rd_chk("R7 flag cleared", FLG, 32'h0);
        chk("R9 irq low after clear", {31'b0, irq_o}, 32'h0);
        wr(SEL, 32'd0); wr(CTRL, 32'h1);
        wr(CNT, 32'hFFFF_FFFF);
        ev_in[5] = 1'b1; idle(1); ev_in[5] = 1'b0;
        rd_chk("R7 event flag set", FLG, 32'h0000_0001);
        chk("R9 irq low when ie clear", {31'b0, irq_o}, 32'h0);
        wr(CNT, 32'hFFFF_FFFF);
        ev_in[5] = 1'b1;
        wr(FLG, 32'h0000_0001);
        ev_in[5] = 1'b0;
        rd_chk("R11 overflow wins over clear", FLG, 32'h0000_0001);
        wr(IES, 32'h1);
        chk("R9 irq on event flag", {31'b0, irq_o}, 32'h1);
        wr(FLG, 32'h0000_0001);
        rd_chk("R7 event flag cleared", FLG, 32'h0);
        wr(CTRL, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_masks();
        t_select();
        t_out_of_range();
        t_counting();
        t_reset_pulses();
        t_cycle();
        t_overflow();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule